// File: doc/BRIEF.md
# Prescaled Multi-Channel Down-Counter Timer

This block is a bank of down-counting timer channels behind a simple APB-style register port. One prescaler divides the bus clock. It turns over every (prescaler reload + 1) clocks, and each turn produces a tick. Every channel counts those ticks down from its own reload value. A channel can stop after a single period or reload itself and run forever. When a channel underflows with its interrupt enabled, it latches a pending flag. Software clears that flag by writing a one to it.

The number of channels (at most eight), the counter width and the prescaler width are parameters. The counter width may be smaller than the 32-bit data bus. Values written to counter or reload registers are truncated to that width, and reads return zeros above it. A build-time option gives each channel its own interrupt line, or ORs all channel interrupts onto a single line. A read-only configuration word reports both the channel count and this option. Only word-aligned addresses (address bits [1:0] = 0) are decoded.

Top module: `tick_timer_bank`

## Requirements
- R1: The prescaler value (read at 0x00) counts down by one each clock. After it reaches 0 it reloads from the prescaler reload register (0x04, read/write, PRE_W bits), so a tick occurs once every (reload + 1) clocks. Writes to 0x00 are ignored.
- R2: The configuration word at 0x08 is read-only. Bits [3:0] hold the channel count and bit 8 is 1 when interrupt lines are separate.
- R3: Channel n uses base 0x10 + 16*n: +0 counter, +4 reload, +8 control, +12 reads zero. Control bits: 0 enable, 1 restart, 2 load, 3 interrupt enable, 4 pending. Writing load copies the reload value into the counter, and load always reads back 0.
- R4: An enabled channel with restart set decrements on each tick. On the tick that finds the counter at 0, it reloads, giving a period of (reload + 1) ticks.
- R5: An enabled channel with restart clear stops on the tick that finds the counter at 0. The counter holds 0 and hardware clears the enable bit.
- R6: An underflow sets pending only when interrupt enable is set. A channel's interrupt is high exactly while its pending and interrupt-enable bits are both 1.
- R7: Writing 1 to control bit 4 clears pending, and writing 0 leaves it unchanged. An underflow in the same cycle as a clear leaves pending set.
- R8: Counter and reload writes keep only the low CNT_W bits. Reads of those registers return zero above bit CNT_W-1, so writing all ones reads back the width mask.
- R9: A disabled channel holds its count, and a write to the counter register loads the written value.
- R10: With separate lines, irq_o bit n is channel n's interrupt. Otherwise irq_o is one bit, the OR of all channel interrupts.
- R11: After reset, every register and prescaler value reads zero and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Select for this block |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_o | output | SEP_IRQ ? NUM_CH : 1 | Interrupt lines |

## Verification
A behavioural model tracks the prescaler and every channel, and it is compared every cycle against both interrupt outputs of two instances: one built with separate lines and one built with a shared line.

Four channel set-ups are run against the same prescaler:
- Periodic with interrupts on. This separates the reload path from the stop path.
- One-shot. This shows the enable bit cleared by hardware and the parked count.
- Periodic with interrupts off. This shows that pending is gated by interrupt enable.
- Disabled, with oversized writes. This exposes truncation and hold behaviour.

A zero write followed by a one write to the pending bit tells write-one-to-clear apart from plain storage.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word bit positions
  localparam int CTL_EN = 0;
  localparam int CTL_RS = 1;
  localparam int CTL_LD = 2;
  localparam int CTL_IE = 3;
  localparam int CTL_IP = 4;

  // fixed register offsets
  localparam int OFF_PRE_VAL = 'h00;
  localparam int OFF_PRE_RLD = 'h04;
  localparam int OFF_CFG     = 'h08;
  localparam int CFG_SEP_BIT = 8;

  typedef struct packed {
    logic ip;
    logic ie;
    logic rs;
    logic en;
  } ch_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] rld_i,
  output logic [PRE_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (tick_o) cnt_q <= rld_i;
    else cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             wr_cnt_i,
  input  logic             wr_rld_i,
  input  logic             wr_ctl_i,
  input  logic [CNT_W-1:0] wval_i,
  input  logic [4:0]       wctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output ch_ctl_t          ctl_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q, rld_q;
  ch_ctl_t          ctl_q;
  logic             step, at_zero, set_ip, clr_ip;

  assign step    = ctl_q.en & tick_i;
  assign at_zero = (cnt_q == '0);
  assign set_ip  = step & at_zero & ctl_q.ie;
  assign clr_ip  = wr_ctl_i & wctl_i[CTL_IP];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      // counting; bus writes below take precedence
      if (step) begin
        if (!at_zero) cnt_q <= cnt_q - 1'b1;
        else if (ctl_q.rs) cnt_q <= rld_q;
        else ctl_q.en <= 1'b0;
      end
      if (wr_rld_i) rld_q <= wval_i;
      if (wr_cnt_i) cnt_q <= wval_i;
      if (wr_ctl_i) begin
        ctl_q.en <= wctl_i[CTL_EN];
        ctl_q.rs <= wctl_i[CTL_RS];
        ctl_q.ie <= wctl_i[CTL_IE];
        if (wctl_i[CTL_LD]) cnt_q <= rld_q;
      end
      ctl_q.ip <= set_ip | (ctl_q.ip & ~clr_ip);
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign ctl_o = ctl_q;
  assign irq_o = ctl_q.ip & ctl_q.ie;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int PRE_W   = 8,
  parameter int ADDR_W  = 8,
  parameter bit SEP_IRQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic [(SEP_IRQ ? NUM_CH : 1)-1:0] irq_o
);
  localparam int SLOT_W = ADDR_W - 4;

  logic                          bus_wr;
  logic                          pre_tick;
  logic [PRE_W-1:0]              pre_cnt, pre_rld_q;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_all, rld_all;
  logic [NUM_CH-1:0]             en_all, rs_all, ie_all, pend_all, ch_irq;

  assign bus_wr = psel & penable & pwrite & (paddr[1:0] == 2'b00);

  always_ff @(posedge clk) begin
    if (rst) pre_rld_q <= '0;
    else if (bus_wr && paddr == ADDR_W'(OFF_PRE_RLD)) pre_rld_q <= pwdata[PRE_W-1:0];
  end

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .rld_i(pre_rld_q), .cnt_o(pre_cnt), .tick_o(pre_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic    slot_hit;
    ch_ctl_t ctl;
    assign slot_hit = bus_wr && (paddr[ADDR_W-1:4] == SLOT_W'(g + 1));
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (pre_tick),
      .wr_cnt_i (slot_hit && paddr[3:2] == 2'd0),
      .wr_rld_i (slot_hit && paddr[3:2] == 2'd1),
      .wr_ctl_i (slot_hit && paddr[3:2] == 2'd2),
      .wval_i   (pwdata[CNT_W-1:0]),
      .wctl_i   (pwdata[4:0]),
      .cnt_o    (cnt_all[g]),
      .rld_o    (rld_all[g]),
      .ctl_o    (ctl),
      .irq_o    (ch_irq[g])
    );
    assign en_all[g]   = ctl.en;
    assign rs_all[g]   = ctl.rs;
    assign ie_all[g]   = ctl.ie;
    assign pend_all[g] = ctl.ip;
  end

  if (SEP_IRQ) begin : g_sep
    assign irq_o = ch_irq;
  end else begin : g_shr
    assign irq_o = |ch_irq;
  end

  always_comb begin
    prdata = '0;
    if (paddr[1:0] == 2'b00) begin
      if (paddr == ADDR_W'(OFF_PRE_VAL)) prdata = 32'(pre_cnt);
      if (paddr == ADDR_W'(OFF_PRE_RLD)) prdata = 32'(pre_rld_q);
      if (paddr == ADDR_W'(OFF_CFG)) begin
        prdata[3:0]         = 4'(NUM_CH);
        prdata[CFG_SEP_BIT] = SEP_IRQ;
      end
      for (int i = 0; i < NUM_CH; i++) begin
        if (paddr[ADDR_W-1:4] == SLOT_W'(i + 1)) begin
          case (paddr[3:2])
            2'd0:    prdata = 32'(cnt_all[i]);
            2'd1:    prdata = 32'(rld_all[i]);
            2'd2:    prdata = 32'({pend_all[i], ie_all[i], 1'b0, rs_all[i], en_all[i]});
            default: prdata = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         psel,
  input logic                         penable,
  input logic                         pwrite,
  input logic [ADDR_W-1:0]            paddr,
  input logic [31:0]                  prdata,
  input logic                         tick,
  input logic [PRE_W-1:0]             pre_rld,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_all,
  input logic [NUM_CH-1:0]            en_all,
  input logic [NUM_CH-1:0]            ie_all,
  input logic [NUM_CH-1:0]            pend_all
);
  logic any_wr, slot_rd;
  assign any_wr  = psel & penable & pwrite;
  assign slot_rd = psel & ~pwrite & (paddr >= ADDR_W'(16)) & (paddr[1:0] == 2'b00);

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && pre_rld != '0) |=> !tick);

  // R8
  rd_width_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_rd && !paddr[3]) |-> ((prdata >> CNT_W) == 32'd0));

  // R3
  ld_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_rd && paddr[3:2] == 2'd2) |-> !prdata[2]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    // R6
    pend_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_all[g]) |-> $past(ie_all[g]));
    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_all[g] && !any_wr) |=> $stable(cnt_all[g]));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(
  .NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .tick(pre_tick), .pre_rld(pre_rld_q),
  .cnt_all(cnt_all), .en_all(en_all), .ie_all(ie_all), .pend_all(pend_all)
);

// File: tb/tick_timer_bank_tb_top.sv
module tick_timer_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 16;
  localparam int PRE_W  = 8;
  localparam int ADDR_W = 8;
  localparam longint CNT_MASK = (64'd1 << CNT_W) - 1;
  localparam longint PRE_MASK = (64'd1 << PRE_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_sh;
  logic [NUM_CH-1:0] irq_sep;
  logic [0:0] irq_sh;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .SEP_IRQ(1'b1)) dut_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_sep));

  tick_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W), .SEP_IRQ(1'b0)) dut_sh_i (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata_sh), .irq_o(irq_sh));

  // ---------------- behavioural reference model ----------------
  longint m_pre_cnt, m_pre_rld;
  longint m_cnt[NUM_CH], m_rld[NUM_CH];
  bit m_en[NUM_CH], m_rs[NUM_CH], m_ie[NUM_CH], m_pd[NUM_CH];
  bit tk, wr, set_b, clr_b;
  int base;

  always @(posedge clk) begin
    if (rst) begin
      m_pre_cnt = 0; m_pre_rld = 0;
      for (int i = 0; i < NUM_CH; i++) begin
        m_cnt[i] = 0; m_rld[i] = 0; m_en[i] = 0; m_rs[i] = 0; m_ie[i] = 0; m_pd[i] = 0;
      end
    end else begin
      wr = psel && penable && pwrite && (paddr[1:0] == 2'b00);
      tk = (m_pre_cnt == 0);
      m_pre_cnt = tk ? m_pre_rld : m_pre_cnt - 1;
      if (wr && paddr == 4) m_pre_rld = pwdata & PRE_MASK;
      for (int i = 0; i < NUM_CH; i++) begin
        base  = 16 * (i + 1);
        set_b = m_en[i] && tk && m_cnt[i] == 0 && m_ie[i];
        clr_b = 0;
        if (m_en[i] && tk) begin
          if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
          else if (m_rs[i]) m_cnt[i] = m_rld[i];
          else m_en[i] = 0;
        end
        if (wr && paddr == base + 4) m_rld[i] = pwdata & CNT_MASK;
        if (wr && paddr == base) m_cnt[i] = pwdata & CNT_MASK;
        if (wr && paddr == base + 8) begin
          m_en[i] = pwdata[0]; m_rs[i] = pwdata[1]; m_ie[i] = pwdata[3];
          if (pwdata[2]) m_cnt[i] = m_rld[i];
          clr_b = pwdata[4];
        end
        m_pd[i] = set_b || (m_pd[i] && !clr_b);
      end
    end
  end

  function automatic longint m_read(int a, bit sep);
    int idx;
    if (a == 0) return m_pre_cnt;
    if (a == 4) return m_pre_rld;
    if (a == 8) return (sep ? 32'h100 : 32'h0) | NUM_CH;
    if (a < 16 || a >= 16 * (NUM_CH + 1) || (a % 4) != 0) return 0;
    idx = a / 16 - 1;
    case ((a / 4) % 4)
      0: return m_cnt[idx];
      1: return m_rld[idx];
      2: return {m_pd[idx], m_ie[idx], 1'b0, m_rs[idx], m_en[idx]};
      default: return 0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic check(input longint got, input longint exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // every clock: interrupt lines of both instances against the model (R6 R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit any;
      any = 0;
      for (int i = 0; i < NUM_CH; i++) begin
        check(irq_sep[i], m_pd[i] && m_ie[i], "R6 separate line");
        any = any | (m_pd[i] && m_ie[i]);
      end
      check(irq_sh[0], any, "R10 shared line");
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = ADDR_W'(a); pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  // read, compare both instances to the model, return the separate instance's value
  task automatic bus_read(input int a, input string tag, output logic [31:0] v);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = ADDR_W'(a);
    @(negedge clk); penable = 1;
    #1;
    v = prdata;
    check(prdata, m_read(a, 1), tag);
    check(prdata_sh, m_read(a, 0), tag);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset state
    check(irq_sep, 0, "R11 irq after reset");
    check(irq_sh, 0, "R11 shared irq after reset");
    bus_read(4, "R11", v);  check(v, 0, "R11 prescaler reload");
    bus_read(16'h18, "R11", v); check(v, 0, "R11 control");
    bus_read(16'h10, "R11", v); check(v, 0, "R11 counter");

    // R2 configuration, read-only
    bus_read(8, "R2", v); check(v, 32'h104, "R2 config word");
    bus_write(8, 32'hFFFF_FFFF);
    bus_read(8, "R2", v); check(v, 32'h104, "R2 config after write");

    // R1 prescaler divide by 3, value register ignores writes
    bus_write(4, 32'h0000_0302);
    bus_read(4, "R1", v); check(v, 2, "R1 reload truncated to PRE_W");
    bus_write(0, 32'h55);
    for (int k = 0; k < 4; k++) bus_read(0, "R1", v);

    // R4 periodic with interrupt, channel 0
    bus_write(16'h14, 4);
    bus_write(16'h18, 32'h0F);
    for (int k = 0; k < 12; k++) begin
      bus_read(16'h10, "R4", v);
      idle(2);
    end
    bus_read(16'h18, "R6", v); check(v[4], 1, "R6 pending after underflow");

    // R7 write zero keeps pending, write one clears it
    bus_write(16'h18, 32'h03);
    bus_read(16'h18, "R7", v); check(v[4], 1, "R7 zero write keeps pending");
    bus_write(16'h18, 32'h13);
    bus_read(16'h18, "R7", v); check(v[4], 0, "R7 one write clears pending");
    idle(20);
    bus_read(16'h18, "R6", v); check(v[4], 0, "R6 no pending while ie off");

    // R5 one-shot, channel 1
    bus_write(16'h24, 3);
    bus_write(16'h28, 32'h0D);
    idle(40);
    bus_read(16'h28, "R5", v); check(v, 32'h18, "R5 enable cleared, pending set");
    bus_read(16'h20, "R5", v); check(v, 0, "R5 counter parked at zero");
    check(irq_sep[1], 1, "R10 channel 1 line");
    check(irq_sh, 1, "R10 shared line high");

    // R6 periodic without interrupt enable, channel 2
    bus_write(16'h34, 1);
    bus_write(16'h38, 32'h07);
    idle(30);
    bus_read(16'h38, "R6", v); check(v, 32'h03, "R6 no pending without ie, R3 load reads 0");
    bus_read(16'h3C, "R3", v); check(v, 0, "R3 reserved word");

    // R8 width truncation and R9 hold, channel 3
    bus_write(16'h44, 32'hFFFF_FFFF);
    bus_read(16'h44, "R8", v); check(v, 32'h0000_FFFF, "R8 reload width mask");
    bus_write(16'h40, 32'hABCD_1234);
    bus_read(16'h40, "R9", v); check(v, 32'h1234, "R9 counter write truncated");
    idle(25);
    bus_read(16'h40, "R9", v); check(v, 32'h1234, "R9 disabled channel holds");
    bus_write(16'h48, 32'h04);
    bus_read(16'h40, "R3", v); check(v, 32'hFFFF, "R3 load copies reload");
    bus_read(16'h48, "R3", v); check(v, 0, "R3 load bit reads zero");

    // clear channel 1 pending: shared line must follow
    bus_write(16'h28, 32'h18);
    idle(5);
    check(irq_sh, 0, "R10 shared line low after clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule